// File: doc/BRIEF.md
# Branch Target Cache with Next-Fetch Selection

This block sits beside the fetch stage of a pipelined core. It keeps a small direct-mapped cache that maps the address of a branch to the address it jumped to last time. Each cycle, fetch presents its PC and an external taken/not-taken guess. The block answers at once with a hit flag, the cached target and the address to fetch next. That address is the cached target when the entry hits and the guess says taken. In every other case it is the sequential address, four bytes on.

When a branch resolves later in the pipe, the block receives the branch address, the real outcome, the real target, and what fetch acted on for that branch. A taken branch installs or refreshes its entry. The block compares the outcome with what fetch did and flags three kinds of error. The first is a taken branch that fetch did not redirect. The second is a redirect to the wrong address. The third is a redirect for a branch that was not taken. On any of these it raises a one-cycle mispredict with the address fetch should restart from.

Top module: `branch_target_unit`

## Requirements
- R1: Reset clears every valid flag, so a lookup of any address right after reset reports no hit.
- R2: On a lookup miss, the next fetch address is the fetch PC plus 4.
- R3: On a lookup hit, the next fetch address is the stored target when the direction input is 1, and the fetch PC plus 4 when it is 0. The stored target is shown on the target output.
- R4: The entry is chosen by PC bits [5:2] with the default of 16 entries. A hit also needs the stored tag to equal PC bits [31:6], so two addresses that share an index but differ above it never alias. PC bits [1:0] are ignored.
- R5: A resolution with taken = 1 writes valid, tag and target into the indexed entry at the clock edge. It overwrites any other branch held there, and lookups see the new entry from the next cycle on.
- R6: A resolution with taken = 0 leaves the buffer unchanged.
- R7: A taken resolution raises a mispredict when fetch did not follow a hit (pred_hit = 0), or when the target it used differs from the real target. The corrected address is the real target.
- R8: A not-taken resolution for which fetch followed a hit (pred_hit = 1) raises a mispredict. The corrected address is the branch PC plus 4.
- R9: The mispredict flag and its address are registered. They appear in the cycle after the resolution input and last one cycle. A resolution that fetch predicted correctly raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fe_pc | input | PC_W | Address being fetched |
| fe_dir_taken | input | 1 | Direction guess for the fetched address, 1 = taken |
| fe_hit | output | 1 | Lookup found a valid entry with matching tag |
| fe_target | output | PC_W | Target held in the indexed entry |
| fe_next_pc | output | PC_W | Address to fetch next |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| rs_target | input | PC_W | Real target of the branch |
| rs_pred_hit | input | 1 | Fetch redirected this branch through a buffer hit |
| rs_pred_target | input | PC_W | Address fetch redirected to when rs_pred_hit is 1 |
| mp_valid | output | 1 | One-cycle mispredict flag |
| mp_pc | output | PC_W | Corrected fetch address while mp_valid is 1 |

## Verification
The hardest case to reach is a stale or displaced entry. This happens when a branch hits on a target that has since changed, or when an aliasing branch has replaced it between install and lookup. Random stimulus draws addresses from a pool with only four tags per index, so index collisions and overwrites happen often. The fetch-side prediction it reports at resolution sometimes carries a deliberately wrong target. Directed steps first build one such displacement on purpose and check that the displaced branch then misses.

// File: rtl/btu_pkg.sv
package btu_pkg;
  localparam int unsigned ALIGN_W    = 2;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic [1:0] {
    MP_NONE,
    MP_UNSEEN_TAKEN,
    MP_BAD_TARGET,
    MP_FALSE_TAKEN
  } mp_kind_e;
endpackage

// File: rtl/btu_store.sv
module btu_store
  import btu_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(ENTRIES)-1:0]        rd_idx,
  output logic                              rd_valid,
  output logic [PC_W-$clog2(ENTRIES)-ALIGN_W-1:0] rd_tag,
  output logic [PC_W-1:0]                   rd_tgt,
  input  logic                              wr_en,
  input  logic [$clog2(ENTRIES)-1:0]        wr_idx,
  input  logic [PC_W-$clog2(ENTRIES)-ALIGN_W-1:0] wr_tag,
  input  logic [PC_W-1:0]                   wr_tgt
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_en && wr_idx == IDX_W'(e)) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_tgt;
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_tgt   = tgt_q[rd_idx];

  // R1: every entry is invalid once reset has been applied
  a_r1_cleared: assert property (@(posedge clk) $past(!rst_n) |-> vld_q == '0);

  // R5: a write leaves the entry valid with the written target
  a_r5_installed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && tgt_q[$past(wr_idx)] == $past(wr_tgt));

  // R6: without a write the valid flags do not move
  a_r6_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/btu_lookup.sv
module btu_lookup
  import btu_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic [PC_W-1:0]                   pc,
  input  logic                              dir_taken,
  output logic [$clog2(ENTRIES)-1:0]        rd_idx,
  input  logic                              ent_valid,
  input  logic [PC_W-$clog2(ENTRIES)-ALIGN_W-1:0] ent_tag,
  input  logic [PC_W-1:0]                   ent_tgt,
  output logic                              hit,
  output logic [PC_W-1:0]                   target,
  output logic [PC_W-1:0]                   next_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] a);
    return a[IDX_W+ALIGN_W-1:ALIGN_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] a);
    return a[PC_W-1:IDX_W+ALIGN_W];
  endfunction

  function automatic logic [PC_W-1:0] seq_of(input logic [PC_W-1:0] a);
    return a + PC_W'(INSN_BYTES);
  endfunction

  logic follow;

  assign rd_idx  = idx_of(pc);
  assign hit     = ent_valid && (ent_tag == tag_of(pc));
  assign target  = ent_tgt;
  assign follow  = hit && dir_taken;
  assign next_pc = follow ? ent_tgt : seq_of(pc);
endmodule

// File: rtl/btu_resolve.sv
module btu_resolve
  import btu_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_pred_hit,
  input  logic [PC_W-1:0] rs_pred_target,
  output logic            mp_valid,
  output logic [PC_W-1:0] mp_pc
);
  function automatic logic [PC_W-1:0] fix_of(input logic taken,
                                             input logic [PC_W-1:0] pc,
                                             input logic [PC_W-1:0] tgt);
    return taken ? tgt : pc + PC_W'(INSN_BYTES);
  endfunction

  mp_kind_e kind;

  always_comb begin
    kind = MP_NONE;
    if (rs_valid) begin
      if (rs_taken) begin
        if (!rs_pred_hit)                     kind = MP_UNSEEN_TAKEN;
        else if (rs_pred_target != rs_target) kind = MP_BAD_TARGET;
      end else if (rs_pred_hit) begin
        kind = MP_FALSE_TAKEN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp_valid <= 1'b0;
      mp_pc    <= '0;
    end else begin
      mp_valid <= (kind != MP_NONE);
      mp_pc    <= fix_of(rs_taken, rs_pc, rs_target);
    end
  end

  // R9: a mispredict only follows a resolution one cycle earlier
  a_r9_from_resolution: assert property (@(posedge clk) disable iff (!rst_n)
    mp_valid |-> $past(rs_valid));

  // R7: a taken branch restarts at its real target
  a_r7_taken_fix: assert property (@(posedge clk) disable iff (!rst_n)
    mp_valid && $past(rs_taken) |-> mp_pc == $past(rs_target));
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fe_pc,
  input  logic            fe_dir_taken,
  output logic            fe_hit,
  output logic [PC_W-1:0] fe_target,
  output logic [PC_W-1:0] fe_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_pred_hit,
  input  logic [PC_W-1:0] rs_pred_target,
  output logic            mp_valid,
  output logic [PC_W-1:0] mp_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0] rd_idx;
  logic             ent_valid;
  logic [TAG_W-1:0] ent_tag;
  logic [PC_W-1:0]  ent_tgt;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;

  assign wr_en  = rs_valid && rs_taken;
  assign wr_idx = rs_pc[IDX_W+ALIGN_W-1:ALIGN_W];
  assign wr_tag = rs_pc[PC_W-1:IDX_W+ALIGN_W];

  btu_store #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_tgt(ent_tgt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(rs_target)
  );

  btu_lookup #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_lookup (
    .pc(fe_pc), .dir_taken(fe_dir_taken), .rd_idx(rd_idx),
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_tgt(ent_tgt),
    .hit(fe_hit), .target(fe_target), .next_pc(fe_next_pc)
  );

  btu_resolve #(.PC_W(PC_W)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_hit(rs_pred_hit),
    .rs_pred_target(rs_pred_target),
    .mp_valid(mp_valid), .mp_pc(mp_pc)
  );

  // R2: a miss falls through to the sequential address
  a_r2_miss_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_hit |-> fe_next_pc == fe_pc + PC_W'(INSN_BYTES));

  // R3: a hit guessed taken redirects to the cached target
  a_r3_hit_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    fe_hit && fe_dir_taken |-> fe_next_pc == fe_target);

  // R8: a not-taken mispredict needs a followed hit and restarts sequentially
  a_r8_false_taken: assert property (@(posedge clk) disable iff (!rst_n)
    mp_valid && !$past(rs_taken) |->
      $past(rs_pred_hit) && mp_pc == $past(rs_pc) + PC_W'(INSN_BYTES));
endmodule

// File: tb/sim_branch_target_unit.sv
module sim_branch_target_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fe_pc;
  logic        fe_dir_taken;
  logic        fe_hit;
  logic [31:0] fe_target;
  logic [31:0] fe_next_pc;
  logic        rs_valid;
  logic [31:0] rs_pc;
  logic        rs_taken;
  logic [31:0] rs_target;
  logic        rs_pred_hit;
  logic [31:0] rs_pred_target;
  logic        mp_valid;
  logic [31:0] mp_pc;

  int tests_run = 0;
  int tests_failed = 0;

  bit          m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];

  always #5 clk = ~clk;

  branch_target_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .fe_pc(fe_pc), .fe_dir_taken(fe_dir_taken),
    .fe_hit(fe_hit), .fe_target(fe_target), .fe_next_pc(fe_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_hit(rs_pred_hit),
    .rs_pred_target(rs_pred_target),
    .mp_valid(mp_valid), .mp_pc(mp_pc)
  );

  function automatic int slot(input logic [31:0] a);
    return int'(a[5:2]);
  endfunction

  function automatic bit m_hit(input logic [31:0] a);
    return m_v[slot(a)] && (m_tag[slot(a)] == a[31:6]);
  endfunction

  function automatic logic [31:0] pool_pc();
    logic [31:0] t = $urandom_range(3);
    logic [31:0] i = $urandom_range(15);
    return 32'h4000_0000 | (t << 6) | (i << 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input bit dir, input string req);
    bit          eh;
    logic [31:0] en;
    @(negedge clk);
    fe_pc = pc;
    fe_dir_taken = dir;
    #1;
    eh = m_hit(pc);
    en = (eh && dir) ? m_tgt[slot(pc)] : pc + 32'd4;
    chk(fe_hit == eh, {req, " hit"}, 32'(fe_hit), 32'(eh));
    if (eh) chk(fe_target == m_tgt[slot(pc)], {req, " target"}, fe_target, m_tgt[slot(pc)]);
    chk(fe_next_pc == en, {req, " next_pc"}, fe_next_pc, en);
  endtask

  task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                         input bit ph, input logic [31:0] pt, input string req);
    bit          emp;
    logic [31:0] epc;
    @(negedge clk);
    rs_valid = 1'b1;
    rs_pc = pc;
    rs_taken = tk;
    rs_target = tgt;
    rs_pred_hit = ph;
    rs_pred_target = pt;
    emp = tk ? (!ph || pt != tgt) : ph;
    epc = tk ? tgt : pc + 32'd4;
    @(posedge clk);
    if (tk) begin
      m_v[slot(pc)] = 1'b1;
      m_tag[slot(pc)] = pc[31:6];
      m_tgt[slot(pc)] = tgt;
    end
    @(negedge clk);
    rs_valid = 1'b0;
    chk(mp_valid == emp, {req, " mp_valid"}, 32'(mp_valid), 32'(emp));
    if (emp) chk(mp_pc == epc, {req, " mp_pc"}, mp_pc, epc);
    @(negedge clk);
    chk(mp_valid == 1'b0, "R9 single pulse", 32'(mp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
    rst_n = 1'b0;
    fe_pc = '0; fe_dir_taken = 1'b0;
    rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; rs_target = '0;
    rs_pred_hit = 1'b0; rs_pred_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(mp_valid == 1'b0, "R9 reset mp_valid", 32'(mp_valid), 32'd0);

    // R1: no entry hits after reset
    for (int i = 0; i < 16; i++) look(32'h0000_1000 | (32'(i) << 2), 1'b1, "R1 reset miss");

    // R7 unseen taken installs (R5) then redirects (R3)
    resolve(32'h0000_0100, 1'b1, 32'h0000_2000, 1'b0, 32'h0, "R7 unseen taken");
    look(32'h0000_0100, 1'b1, "R5 R3 hit taken");
    look(32'h0000_0100, 1'b0, "R3 hit not-taken");
    look(32'h0000_0103, 1'b1, "R4 low bits ignored");
    // R4 same index, other tag
    look(32'h0000_0140, 1'b1, "R4 alias miss");
    look(32'h0000_0104, 1'b1, "R2 miss seq");
    // R8 followed hit resolves not taken; R6 buffer unchanged
    resolve(32'h0000_0100, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_2000, "R8 false taken");
    look(32'h0000_0100, 1'b1, "R6 entry kept");
    resolve(32'h0000_0100, 1'b1, 32'h0000_2000, 1'b1, 32'h0000_2000, "R9 correct");
    resolve(32'h0000_0100, 1'b1, 32'h0000_2000, 1'b1, 32'h0000_3000, "R7 bad target");
    resolve(32'h0000_0100, 1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000, "R9 correct not-taken");
    // R5 alias displaces the old entry
    resolve(32'h0000_0140, 1'b1, 32'h0000_4000, 1'b0, 32'h0, "R7 alias install");
    look(32'h0000_0100, 1'b1, "R5 displaced miss");
    look(32'h0000_0140, 1'b1, "R5 new owner hit");
    // R5 refresh with a new target
    resolve(32'h0000_0140, 1'b1, 32'h0000_4800, 1'b1, 32'h0000_4000, "R7 moved target");
    look(32'h0000_0140, 1'b1, "R5 refreshed target");
    // R2 wrap at the top of the address space
    look(32'hFFFF_FFFC, 1'b1, "R2 wrap");

    for (int n = 0; n < 1500; n++) begin
      logic [31:0] p = pool_pc();
      logic [31:0] tg = {$urandom_range(32'hFFFF), 2'b00};
      bit tk = ($urandom_range(1) == 1);
      bit ph = m_hit(p) && ($urandom_range(3) != 0);
      logic [31:0] pt = m_tgt[slot(p)];
      if ($urandom_range(7) == 0) ph = !ph;
      if ($urandom_range(3) == 0) pt = tg;
      look(pool_pc(), ($urandom_range(1) == 1), "R3 R4 random lookup");
      resolve(p, tk, tg, ph, pt, "R7 R8 R9 random resolve");
    end

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule